// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block holds a small bank of semaphores that several processors share. Each processor has one request channel. It raises a request, selects a semaphore by index and chooses between a wait (down) operation and a signal (up) operation. It then holds all three until the block answers with a grant pulse. A signal is always completed in the cycle it is presented. A wait is completed in the cycle its semaphore is positive and the processor wins arbitration. Until then the wait stays pending, and the processor keeps its request raised.

Each semaphore is fixed at build time as binary, counting, or a member of one split binary set. Every operation tests and updates the value in a single clock edge, so no other processor can see a half-finished update. A signal that cannot be applied still completes, but it leaves the value unchanged and pulses an error flag on that requester's channel. Contention for one semaphore is settled by a rotating priority for each semaphore, so a waiting processor cannot be passed over indefinitely.

Top module: `hw_sem_bank`

## Requirements
- R1: After reset each semaphore holds its configured initial value (default build: semaphore 0 = 1, semaphore 1 = 2, semaphore 2 = 1, semaphore 3 = 0), and with no request raised every grant and error bit is 0.
- R2: A wait request (op bit 0) to a positive semaphore that wins arbitration sees its grant bit high in the same cycle, and the value drops by exactly one at the next clock edge.
- R3: A wait request to a semaphore whose value is 0, with no signal to it in that cycle, keeps its grant bit low and changes nothing.
- R4: A signal request (op bit 1) is granted in the cycle it is presented and raises the value by one. Signals to different semaphores in one cycle are independent of each other.
- R5: A binary semaphore holds only 0 or 1. A signal to it while it holds 1 is granted, leaves it at 1 and sets that requester's error bit in the same cycle.
- R6: A counting semaphore saturates at 2^CNT_W-1 (15 by default). A signal at that value is granted, leaves the value unchanged and sets the error bit.
- R7: The members of the split set (semaphores 2 and 3 by default) never sum to more than 1. A signal to a member while any member holds 1 is granted, changes nothing and sets the error bit.
- R8: At most one wait is granted per semaphore per cycle. The winner is the first waiting requester, in rising index order with wraparound, at or after the requester that follows the previous winner on that semaphore. The rotation starts at requester 0 after reset.
- R9: A signal and a wait to the same semaphore in one cycle are applied signal first, so the wait can be granted in that same cycle even if the value was 0.
- R10: A requester waiting on a semaphore is granted before the other requesters receive NUM_REQ grants on that semaphore.
- R11: Several signals to one semaphore in one cycle are applied in rising requester order, and each one counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_REQ | Request valid, one bit per requester, held until granted |
| op | input | NUM_REQ | Operation per requester: 1 = signal (up), 0 = wait (down) |
| idx | input | NUM_REQ*IDX_W | Semaphore index; requester r uses bits [r*IDX_W +: IDX_W] |
| gnt | output | NUM_REQ | Grant pulse, combinational, valid in the cycle the operation completes |
| err | output | NUM_REQ | Error pulse with a grant for a signal that could not be applied |

## Verification
On every cycle the assertions check the invariants on the stored values: the binary range, the split-set sum and the absence of wrap. They also check the handshake rules: a signal is always granted, no wait is granted on an empty semaphore, at most one wait is granted per semaphore, and the value drops by one after a lone wait. A counter in the checker bounds how many foreign grants a waiter can watch go by. The bench scenarios are needed to show what only ordering can show: which requester the rotation picks next, that a rejected signal really left the value unchanged (seen through later wait grants), and that saturation at the counting limit holds across a full fill and drain.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic {
        OP_DOWN = 1'b0,
        OP_UP   = 1'b1
    } sem_op_e;

    typedef enum logic [1:0] {
        MODE_BINARY  = 2'd0,
        MODE_COUNT   = 2'd1,
        MODE_SPLIT   = 2'd2
    } sem_mode_e;

    // Split membership takes priority over the counting flag.
    function automatic sem_mode_e mode_of(input logic is_count, input logic is_split);
        if (is_split)
            return MODE_SPLIT;
        else if (is_count)
            return MODE_COUNT;
        else
            return MODE_BINARY;
    endfunction

endpackage

// File: rtl/sem_req_decode.sv
module sem_req_decode
    import sem_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int NUM_SEM = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_REQ-1:0]                 req,
    input  logic [NUM_REQ-1:0]                 op,
    input  logic [NUM_REQ*IDX_W-1:0]           idx,
    output logic [NUM_REQ-1:0]                 up_req,
    output logic [NUM_REQ-1:0][IDX_W-1:0]      idx_a,
    output logic [NUM_SEM-1:0][NUM_REQ-1:0]    down_cand
);

    logic [NUM_REQ-1:0] down_req;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        assign idx_a[r]    = idx[r*IDX_W +: IDX_W];
        assign up_req[r]   = req[r] && (sem_op_e'(op[r]) == OP_UP);
        assign down_req[r] = req[r] && (sem_op_e'(op[r]) == OP_DOWN);
    end

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
        for (genvar r = 0; r < NUM_REQ; r++) begin : g_cand
            assign down_cand[s][r] = down_req[r] && (idx_a[r] == IDX_W'(s));
        end
    end

endmodule

// File: rtl/sem_up_stage.sv
module sem_up_stage
    import sem_pkg::*;
#(
    parameter int                NUM_REQ    = 4,
    parameter int                NUM_SEM    = 4,
    parameter int                CNT_W      = 4,
    parameter int                IDX_W      = 2,
    parameter logic [NUM_SEM-1:0] COUNT_MASK = '0,
    parameter logic [NUM_SEM-1:0] SPLIT_MASK = '0
) (
    input  logic [NUM_SEM-1:0][CNT_W-1:0] val_q,
    input  logic [NUM_REQ-1:0]            up_req,
    input  logic [NUM_REQ-1:0][IDX_W-1:0] idx_a,
    output logic [NUM_SEM-1:0][CNT_W-1:0] val_up,
    output logic [NUM_REQ-1:0]            up_err
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    // Signals are folded in one after another in rising requester order.
    always_comb begin
        logic       split_full;
        logic [IDX_W-1:0] sel;
        sem_mode_e  mode;
        val_up     = val_q;
        up_err     = '0;
        split_full = 1'b0;
        sel        = '0;
        mode       = MODE_BINARY;
        for (int s = 0; s < NUM_SEM; s++) begin
            if (SPLIT_MASK[s] && (val_q[s] != '0))
                split_full = 1'b1;
        end
        for (int r = 0; r < NUM_REQ; r++) begin
            if (up_req[r]) begin
                sel  = idx_a[r];
                mode = mode_of(COUNT_MASK[sel], SPLIT_MASK[sel]);
                case (mode)
                    MODE_SPLIT: begin
                        if (split_full) begin
                            up_err[r] = 1'b1;
                        end else begin
                            val_up[sel] = ONE;
                            split_full  = 1'b1;
                        end
                    end
                    MODE_COUNT: begin
                        if (val_up[sel] == CNT_MAX)
                            up_err[r] = 1'b1;
                        else
                            val_up[sel] = val_up[sel] + ONE;
                    end
                    default: begin
                        if (val_up[sel] != '0)
                            up_err[r] = 1'b1;
                        else
                            val_up[sel] = ONE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/sem_rr_arb.sv
module sem_rr_arb #(
    parameter int NUM_REQ = 4,
    parameter int PTR_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] cand,
    input  logic               avail,
    output logic [NUM_REQ-1:0] grant
);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] win;
    logic             found;

    // Scan starts at the requester after the last winner.
    always_comb begin
        int pos;
        grant = '0;
        win   = '0;
        found = 1'b0;
        for (int k = 0; k < NUM_REQ; k++) begin
            pos = (int'(ptr_q) + k) % NUM_REQ;
            if (!found && avail && cand[pos]) begin
                found = 1'b1;
                win   = PTR_W'(pos);
            end
        end
        if (found)
            grant[win] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (found) begin
            if (int'(win) == NUM_REQ - 1)
                ptr_q <= '0;
            else
                ptr_q <= win + PTR_W'(1);
        end
    end

endmodule

// File: rtl/hw_sem_bank.sv
module hw_sem_bank
    import sem_pkg::*;
#(
    parameter int                         NUM_REQ    = 4,
    parameter int                         NUM_SEM    = 4,
    parameter int                         CNT_W      = 4,
    parameter int                         IDX_W      = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1,
    parameter logic [NUM_SEM-1:0]         COUNT_MASK = 4'b0010,
    parameter logic [NUM_SEM-1:0]         SPLIT_MASK = 4'b1100,
    parameter logic [NUM_SEM*CNT_W-1:0]   INIT_VAL   = 16'h0121
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_REQ-1:0]       req,
    input  logic [NUM_REQ-1:0]       op,
    input  logic [NUM_REQ*IDX_W-1:0] idx,
    output logic [NUM_REQ-1:0]       gnt,
    output logic [NUM_REQ-1:0]       err
);

    logic [NUM_SEM-1:0][CNT_W-1:0]   val_q;
    logic [NUM_SEM-1:0][CNT_W-1:0]   val_up;
    logic [NUM_REQ-1:0]              up_req;
    logic [NUM_REQ-1:0]              up_err;
    logic [NUM_REQ-1:0][IDX_W-1:0]   idx_a;
    logic [NUM_SEM-1:0][NUM_REQ-1:0] down_cand;
    logic [NUM_SEM-1:0][NUM_REQ-1:0] down_gnt;
    logic [NUM_SEM-1:0]              down_hit;
    logic [NUM_REQ-1:0]              down_any;

    sem_req_decode #(
        .NUM_REQ (NUM_REQ),
        .NUM_SEM (NUM_SEM),
        .IDX_W   (IDX_W)
    ) u_dec (
        .req       (req),
        .op        (op),
        .idx       (idx),
        .up_req    (up_req),
        .idx_a     (idx_a),
        .down_cand (down_cand)
    );

    sem_up_stage #(
        .NUM_REQ    (NUM_REQ),
        .NUM_SEM    (NUM_SEM),
        .CNT_W      (CNT_W),
        .IDX_W      (IDX_W),
        .COUNT_MASK (COUNT_MASK),
        .SPLIT_MASK (SPLIT_MASK)
    ) u_up (
        .val_q  (val_q),
        .up_req (up_req),
        .idx_a  (idx_a),
        .val_up (val_up),
        .up_err (up_err)
    );

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
        sem_rr_arb #(
            .NUM_REQ (NUM_REQ)
        ) u_arb (
            .clk   (clk),
            .rst   (rst),
            .cand  (down_cand[s]),
            .avail (val_up[s] != '0),
            .grant (down_gnt[s])
        );

        assign down_hit[s] = |down_gnt[s];

        always_ff @(posedge clk) begin
            if (rst)
                val_q[s] <= INIT_VAL[s*CNT_W +: CNT_W];
            else
                val_q[s] <= val_up[s] - {{(CNT_W-1){1'b0}}, down_hit[s]};
        end
    end

    always_comb begin
        down_any = '0;
        for (int s = 0; s < NUM_SEM; s++)
            down_any = down_any | down_gnt[s];
    end

    assign gnt = up_req | down_any;
    assign err = up_err;

endmodule

// File: rtl/hw_sem_bank_chk.sv
module hw_sem_bank_chk #(
    parameter int                 NUM_REQ    = 4,
    parameter int                 NUM_SEM    = 4,
    parameter int                 CNT_W      = 4,
    parameter int                 IDX_W      = 2,
    parameter logic [NUM_SEM-1:0] COUNT_MASK = '0,
    parameter logic [NUM_SEM-1:0] SPLIT_MASK = '0
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_REQ-1:0]            req,
    input logic [NUM_REQ-1:0]            op,
    input logic [NUM_REQ*IDX_W-1:0]      idx,
    input logic [NUM_REQ-1:0]            gnt,
    input logic [NUM_SEM-1:0][CNT_W-1:0] val_q
);

    logic [NUM_REQ-1:0][IDX_W-1:0]   ix;
    logic [NUM_SEM-1:0]              up_hit;
    logic [NUM_SEM-1:0][NUM_REQ-1:0] dn_g;
    logic [NUM_SEM-1:0][NUM_REQ-1:0] dn_r;
    int unsigned                     split_sum;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_ix
        assign ix[r] = idx[r*IDX_W +: IDX_W];
    end

    always_comb begin
        up_hit    = '0;
        dn_g      = '0;
        dn_r      = '0;
        split_sum = 0;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (req[r] && op[r])
                up_hit[ix[r]] = 1'b1;
            if (req[r] && !op[r]) begin
                dn_r[ix[r]][r] = 1'b1;
                dn_g[ix[r]][r] = gnt[r];
            end
        end
        for (int s = 0; s < NUM_SEM; s++)
            if (SPLIT_MASK[s])
                split_sum = split_sum + int'(val_q[s]);
    end

    // R7: split set never holds more than one token
    p_split_sum_r7: assert property (@(posedge clk) disable iff (rst)
        split_sum <= 1);

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
        if (!COUNT_MASK[s]) begin : g_bin
            // R5: binary and split members stay in 0..1
            p_bin_range_r5: assert property (@(posedge clk) disable iff (rst)
                val_q[s] <= CNT_W'(1));
        end

        // R8: one wait grant per semaphore per cycle
        p_one_down_r8: assert property (@(posedge clk) disable iff (rst)
            $countones(dn_g[s]) <= 1);

        // R3: empty semaphore without a signal grants no wait
        p_empty_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (val_q[s] == '0 && !up_hit[s]) |-> (dn_g[s] == '0));

        // R2: a lone wait grant takes exactly one token
        p_down_dec_r2: assert property (@(posedge clk) disable iff (rst)
            ((|dn_g[s]) && !up_hit[s]) |=> (val_q[s] == $past(val_q[s]) - CNT_W'(1)));

        // R6: counting value never wraps from its maximum to zero
        p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
            (val_q[s] == {CNT_W{1'b1}} && !(|dn_g[s])) |=> (val_q[s] == {CNT_W{1'b1}}));
    end

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        logic [7:0]       wait_cnt;
        logic [IDX_W-1:0] ix_q;
        logic             others;

        assign others = |(dn_g[ix[r]] & ~(NUM_REQ'(1) << r));

        always_ff @(posedge clk) begin
            ix_q <= ix[r];
            if (rst || !(req[r] && !op[r]) || gnt[r] || (ix_q != ix[r]))
                wait_cnt <= '0;
            else if (others)
                wait_cnt <= wait_cnt + 8'd1;
        end

        // R4: a signal is always granted in its own cycle
        p_up_granted_r4: assert property (@(posedge clk) disable iff (rst)
            (req[r] && op[r]) |-> gnt[r]);

        // R10: bounded number of foreign grants while waiting
        p_wait_bound_r10: assert property (@(posedge clk) disable iff (rst)
            (req[r] && !op[r]) |-> (int'(wait_cnt) < NUM_REQ));
    end

endmodule

bind hw_sem_bank hw_sem_bank_chk #(
    .NUM_REQ    (NUM_REQ),
    .NUM_SEM    (NUM_SEM),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W),
    .COUNT_MASK (COUNT_MASK),
    .SPLIT_MASK (SPLIT_MASK)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .op    (op),
    .idx   (idx),
    .gnt   (gnt),
    .val_q (val_q)
);

// File: tb/sim_hw_sem_bank.sv
`timescale 1ns/1ps
module sim_hw_sem_bank;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] op  = '0;
    logic [7:0]   idx = '0;
    logic [N-1:0] gnt;
    logic [N-1:0] err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [N-1:0] g;
        logic [N-1:0] e;
        string        tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    hw_sem_bank u0 (
        .clk (clk),
        .rst (rst),
        .req (req),
        .op  (op),
        .idx (idx),
        .gnt (gnt),
        .err (err)
    );

    function automatic logic [7:0] ix(input int a3, input int a2, input int a1, input int a0);
        return {2'(a3), 2'(a2), 2'(a1), 2'(a0)};
    endfunction

    // Driver: apply one cycle of requests and queue the expected answer.
    task automatic step(input logic [N-1:0] rq, input logic [N-1:0] o, input logic [7:0] ixv,
                        input logic [N-1:0] eg, input logic [N-1:0] ee, input string tag);
        exp_t it;
        @(posedge clk);
        #1;
        req = rq;
        op  = o;
        idx = ixv;
        it.g = eg;
        it.e = ee;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare mid-cycle, after the combinational grant settles.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (gnt !== it.g || err !== it.e) begin
                errors++;
                $display("FAIL %s: gnt=%b err=%b expected gnt=%b err=%b",
                         it.tag, gnt, err, it.g, it.e);
            end
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // Reset state, R1
        step(4'b0000, 4'b0000, 8'h00, 4'b0000, 4'b0000, "R1 idle outputs after reset");
        // Semaphore 0 binary, starts at 1
        step(4'b0001, 4'b0000, 8'h00, 4'b0001, 4'b0000, "R1 R2 wait on sem0 at initial 1");
        step(4'b0010, 4'b0000, 8'h00, 4'b0000, 4'b0000, "R3 wait pending on empty sem0");
        step(4'b0010, 4'b0000, 8'h00, 4'b0000, 4'b0000, "R3 wait still pending");
        step(4'b0011, 4'b0001, 8'h00, 4'b0011, 4'b0000, "R9 signal then wait same cycle");
        step(4'b0010, 4'b0000, 8'h00, 4'b0000, 4'b0000, "R9 token consumed by that wait");
        step(4'b0001, 4'b0001, 8'h00, 4'b0001, 4'b0000, "R4 signal on empty sem0");
        step(4'b0001, 4'b0001, 8'h00, 4'b0001, 4'b0001, "R5 signal at 1 flags error");
        step(4'b0010, 4'b0000, 8'h00, 4'b0010, 4'b0000, "R5 one token after rejected signal");
        step(4'b0100, 4'b0000, 8'h00, 4'b0000, 4'b0000, "R5 value was 1 not 2");
        step(4'b0101, 4'b0001, 8'h00, 4'b0101, 4'b0000, "R9 pending waiter served by signal");

        // Semaphore 1 counting, starts at 2: rotation, R8 and R10
        step(4'b1111, 4'b0000, 8'h55, 4'b0001, 4'b0000, "R8 rotation picks r0 first");
        step(4'b1110, 4'b0000, 8'h55, 4'b0010, 4'b0000, "R8 rotation picks r1");
        step(4'b1100, 4'b0000, 8'h55, 4'b0000, 4'b0000, "R3 sem1 exhausted");
        step(4'b1101, 4'b0001, 8'h55, 4'b0101, 4'b0000, "R8 rotation picks r2 after signal");
        step(4'b1011, 4'b0010, 8'h55, 4'b1010, 4'b0000, "R8 R10 r3 served before lower r0");
        step(4'b0011, 4'b0010, 8'h55, 4'b0011, 4'b0000, "R10 r0 served after wrap");

        // R11: two signals in one cycle both count
        step(4'b0011, 4'b0011, 8'h55, 4'b0011, 4'b0000, "R11 two signals same cycle");
        step(4'b0111, 4'b0000, 8'h55, 4'b0010, 4'b0000, "R11 first of two tokens");
        step(4'b0101, 4'b0000, 8'h55, 4'b0100, 4'b0000, "R11 second of two tokens");
        step(4'b0001, 4'b0000, 8'h55, 4'b0000, 4'b0000, "R11 exactly two tokens added");

        // R6: fill to 15, saturate, drain
        for (int k = 0; k < 15; k++)
            step(4'b1000, 4'b1000, 8'h55, 4'b1000, 4'b0000, "R6 fill counting sem1");
        step(4'b1000, 4'b1000, 8'h55, 4'b1000, 4'b1000, "R6 signal at max flags error");
        for (int k = 0; k < 15; k++)
            step(4'b1000, 4'b0000, 8'h55, 4'b1000, 4'b0000, "R6 drain counting sem1");
        step(4'b1000, 4'b0000, 8'h55, 4'b0000, 4'b0000, "R6 held at max, no wrap");

        // R7: split set sem2 (holds 1) and sem3 (holds 0)
        step(4'b0001, 4'b0001, 8'hFF, 4'b0001, 4'b0001, "R7 signal to member while set full");
        step(4'b0010, 4'b0000, 8'hFF, 4'b0000, 4'b0000, "R7 rejected signal left sem3 at 0");
        step(4'b0010, 4'b0000, 8'hAA, 4'b0010, 4'b0000, "R7 take token from sem2");
        step(4'b0001, 4'b0001, 8'hFF, 4'b0001, 4'b0000, "R7 signal sem3 when set empty");
        step(4'b0100, 4'b0000, 8'hAA, 4'b0000, 4'b0000, "R7 sem2 still empty");
        step(4'b0100, 4'b0000, 8'hFF, 4'b0100, 4'b0000, "R7 take token from sem3");
        step(4'b0011, 4'b0011, ix(0, 0, 3, 2), 4'b0011, 4'b0010, "R7 second signal into set rejected");
        step(4'b0100, 4'b0000, 8'hFF, 4'b0000, 4'b0000, "R7 sem3 got nothing");
        step(4'b0100, 4'b0000, 8'hAA, 4'b0100, 4'b0000, "R7 sem2 got the token");

        // R4: signals to different semaphores in one cycle
        step(4'b0011, 4'b0011, ix(0, 0, 1, 0), 4'b0011, 4'b0000, "R4 signals to sem0 and sem1");
        step(4'b0011, 4'b0000, ix(0, 0, 1, 0), 4'b0011, 4'b0000, "R4 both semaphores at 1");

        @(posedge clk);
        #1;
        req = '0;
        wait (sb.size() == 0);
        @(posedge clk);
        done = 1'b1;
        report();
    end

endmodule